// File: doc/BRIEF.md
# Constant-Time Branch Resolution Unit

This block resolves branches and jumps in the execute stage of a simple in-order pipeline and selects the next fetch address. A decoded instruction is presented with its program counter, its length (full-width or compressed), its control-flow kind, the result of the condition comparison and its sign-extended immediate. The unit answers with a one-cycle redirect pulse carrying the new fetch address, and with a stall towards decode/execute when it needs an extra cycle.

A hardening mode makes branch timing independent of the branch condition. It exists only when the `SECURE_AVAIL` parameter is non-zero, and it applies to a branch only while the run-time input `secure_mode_i` is high. In that mode every conditional branch redirects fetch. A failed condition becomes a redirect to the sequential address. The target arithmetic is built in one of two ways, chosen by `DEDICATED_ADDER`:
- A single adder whose second operand is picked by the branch decision. This is how the main ALU would be shared.
- Separate adders for the target and for the sequential address. In this form, secure branches register both candidate addresses and pick one in a second cycle behind a one-cycle stall. This keeps the condition out of the path to the address selector.

The mode bit is captured when the instruction is accepted. An instruction is accepted on a rising edge where `ex_valid_i` is high and `stall_o` is low.

Top module: `ct_branch_unit`

## Requirements
- R1: With `SECURE_AVAIL` = 0 the unit behaves in normal mode whatever the value of `secure_mode_i`.
- R2: With secure mode active, every accepted conditional branch (`ex_kind_i` = 2'b01) produces exactly one redirect pulse, whether `ex_cond_i` is 0 or 1.
- R3: A redirect for a branch with `ex_cond_i` = 0 carries the sequential address: `ex_pc_i` + 2 when `ex_compressed_i` = 1, else `ex_pc_i` + 4, wrapping modulo 2^AW.
- R4: A redirect for a taken branch (`ex_cond_i` = 1) or a jump carries `ex_pc_i` + `ex_imm_i` modulo 2^AW.
- R5: With secure mode inactive, an accepted conditional branch with `ex_cond_i` = 0 produces no redirect and no stall. With `ex_cond_i` = 1 it raises `redirect_o` in the cycle after the accepting edge, with no stall.
- R6: With `DEDICATED_ADDER` = 0, a secure-mode branch raises `redirect_o` in the cycle after the accepting edge, and `stall_o` never rises.
- R7: With `DEDICATED_ADDER` != 0, a secure-mode branch holds `stall_o` high for exactly the one cycle after the accepting edge. `redirect_o` rises in the cycle after that.
- R8: In secure mode the redirect cycle and the number of stall cycles are identical for `ex_cond_i` = 0 and `ex_cond_i` = 1, in both adder configurations.
- R9: A jump (`ex_kind_i` = 2'b10) always redirects in the cycle after the accepting edge, with no stall, whatever the mode.
- R10: `secure_mode_i` is sampled only on the accepting edge. Changing it afterwards does not alter the redirect or the stall of that branch.
- R11: While `stall_o` is high, `ex_valid_i` is ignored and no instruction is accepted.
- R12: Reset (synchronous, active high) clears `redirect_o`, `redirect_pc_o` and `stall_o`. `ex_kind_i` values 2'b00 and 2'b11 and `ex_valid_i` = 0 produce no redirect and no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ex_valid_i | input | 1 | Instruction present in execute |
| ex_kind_i | input | 2 | 00 none, 01 conditional branch, 10 jump, 11 none |
| ex_pc_i | input | AW | Program counter of the instruction |
| ex_compressed_i | input | 1 | 1 for a 2-byte instruction, 0 for 4-byte |
| ex_cond_i | input | 1 | Branch condition result |
| ex_imm_i | input | AW | Sign-extended branch/jump offset |
| secure_mode_i | input | 1 | Run-time enable of the constant-time mode |
| redirect_o | output | 1 | One-cycle fetch redirect pulse |
| redirect_pc_o | output | AW | Fetch address valid while redirect_o is high |
| stall_o | output | 1 | Hold request to decode/execute |

## Verification
Every output is registered. A normal redirect therefore appears in the first cycle after the accepting edge. A secure branch with a dedicated adder shows its stall in that first cycle and its redirect in the second. The bench drives inputs on falling edges and, for each issued instruction, samples all outputs at the three following falling edges. It records the cycle of the first redirect, the number of redirect pulses, the address and the stall count, and compares each against values computed from the requirements. Three instances run in lockstep (dedicated, shared, mode unavailable) over a sweep of kind, condition, length, mode, a mid-flight mode flip, and two address/offset pairs that exercise wrap-around.

// File: rtl/ctb_pkg.sv
package ctb_pkg;
  typedef enum logic [1:0] {
    K_NONE = 2'b00,
    K_COND = 2'b01,
    K_JUMP = 2'b10,
    K_RSVD = 2'b11
  } ctb_kind_e;
endpackage

// File: rtl/ctb_decide.sv
// Control decision: whether to redirect, whether the target is taken,
// and whether the two-cycle secure path is needed.
module ctb_decide #(
  parameter int SECURE_AVAIL    = 1,
  parameter int DEDICATED_ADDER = 1
) (
  input  logic [1:0] kind_i,
  input  logic       cond_i,
  input  logic       mode_i,
  output logic       redirect_o,
  output logic       take_target_o,
  output logic       two_stage_o
);
  import ctb_pkg::*;

  localparam bit HAS_SECURE = (SECURE_AVAIL != 0);
  localparam bit SPLIT      = (DEDICATED_ADDER != 0);

  logic is_cond;
  logic is_jump;
  logic active;

  always_comb begin
    is_cond       = (kind_i == K_COND);
    is_jump       = (kind_i == K_JUMP);
    active        = HAS_SECURE && mode_i;
    take_target_o = is_jump || (is_cond && cond_i);
    redirect_o    = take_target_o || (is_cond && active);
    two_stage_o   = SPLIT && is_cond && active;
  end
endmodule

// File: rtl/ctb_addr_path.sv
// Address arithmetic. Shared form: one adder, operand picked by the
// decision. Dedicated form: independent target and sequential adders.
module ctb_addr_path #(
  parameter int AW              = 32,
  parameter int DEDICATED_ADDER = 1
) (
  input  logic [AW-1:0] pc_i,
  input  logic [AW-1:0] imm_i,
  input  logic          compressed_i,
  input  logic          take_target_i,
  output logic [AW-1:0] addr_o,
  output logic [AW-1:0] target_o,
  output logic [AW-1:0] seq_o
);
  localparam logic [AW-1:0] STEP_FULL = AW'(4);
  localparam logic [AW-1:0] STEP_HALF = AW'(2);

  logic [AW-1:0] step;
  assign step = compressed_i ? STEP_HALF : STEP_FULL;

  generate
    if (DEDICATED_ADDER != 0) begin : g_dedicated
      logic [AW-1:0] tgt_sum;
      logic [AW-1:0] seq_sum;
      assign tgt_sum  = pc_i + imm_i;
      assign seq_sum  = pc_i + step;
      assign target_o = tgt_sum;
      assign seq_o    = seq_sum;
      assign addr_o   = take_target_i ? tgt_sum : seq_sum;
    end else begin : g_shared
      logic [AW-1:0] operand_b;
      logic [AW-1:0] sum;
      assign operand_b = take_target_i ? imm_i : step;
      assign sum       = pc_i + operand_b;
      assign addr_o    = sum;
      assign target_o  = sum;
      assign seq_o     = sum;
    end
  endgenerate
endmodule

// File: rtl/ct_branch_unit.sv
module ct_branch_unit #(
  parameter int AW              = 32,
  parameter int SECURE_AVAIL    = 1,
  parameter int DEDICATED_ADDER = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ex_valid_i,
  input  logic [1:0]    ex_kind_i,
  input  logic [AW-1:0] ex_pc_i,
  input  logic          ex_compressed_i,
  input  logic          ex_cond_i,
  input  logic [AW-1:0] ex_imm_i,
  input  logic          secure_mode_i,
  output logic          redirect_o,
  output logic [AW-1:0] redirect_pc_o,
  output logic          stall_o
);
  logic          want_redirect;
  logic          take_target;
  logic          two_stage;
  logic [AW-1:0] addr_now;
  logic [AW-1:0] cand_target;
  logic [AW-1:0] cand_seq;
  logic          accept;

  // Second-cycle state of a secure branch (dedicated adders only).
  logic          pend_cond;
  logic [AW-1:0] pend_target;
  logic [AW-1:0] pend_seq;

  assign accept = ex_valid_i && !stall_o;

  ctb_decide #(
    .SECURE_AVAIL   (SECURE_AVAIL),
    .DEDICATED_ADDER(DEDICATED_ADDER)
  ) u_decide (
    .kind_i       (ex_kind_i),
    .cond_i       (ex_cond_i),
    .mode_i       (secure_mode_i),
    .redirect_o   (want_redirect),
    .take_target_o(take_target),
    .two_stage_o  (two_stage)
  );

  ctb_addr_path #(
    .AW             (AW),
    .DEDICATED_ADDER(DEDICATED_ADDER)
  ) u_addr (
    .pc_i         (ex_pc_i),
    .imm_i        (ex_imm_i),
    .compressed_i (ex_compressed_i),
    .take_target_i(take_target),
    .addr_o       (addr_now),
    .target_o     (cand_target),
    .seq_o        (cand_seq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      redirect_o    <= 1'b0;
      redirect_pc_o <= '0;
      stall_o       <= 1'b0;
      pend_cond     <= 1'b0;
      pend_target   <= '0;
      pend_seq      <= '0;
    end else begin
      redirect_o <= 1'b0;
      stall_o    <= 1'b0;
      if (stall_o) begin
        // Condition only steers a registered select here.
        redirect_o    <= 1'b1;
        redirect_pc_o <= pend_cond ? pend_target : pend_seq;
      end else if (accept) begin
        if (two_stage) begin
          stall_o     <= 1'b1;
          pend_cond   <= ex_cond_i;
          pend_target <= cand_target;
          pend_seq    <= cand_seq;
        end else if (want_redirect) begin
          redirect_o    <= 1'b1;
          redirect_pc_o <= addr_now;
        end
      end
    end
  end
endmodule

// File: rtl/ct_branch_unit_chk.sv
module ct_branch_unit_chk #(
  parameter int AW              = 32,
  parameter int SECURE_AVAIL    = 1,
  parameter int DEDICATED_ADDER = 1
) (
  input logic          clk,
  input logic          rst,
  input logic          ex_valid_i,
  input logic [1:0]    ex_kind_i,
  input logic [AW-1:0] ex_pc_i,
  input logic          ex_cond_i,
  input logic [AW-1:0] ex_imm_i,
  input logic          secure_mode_i,
  input logic          redirect_o,
  input logic [AW-1:0] redirect_pc_o,
  input logic          stall_o
);
  logic acc;
  logic sec_on;
  assign acc    = ex_valid_i && !stall_o;
  assign sec_on = (SECURE_AVAIL != 0) && secure_mode_i;

  // R12
  a_r12_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!redirect_o && !stall_o));

  // R7
  a_r7_stall_one: assert property (@(posedge clk) disable iff (rst)
    stall_o |=> !stall_o);

  // R7
  a_r7_stall_then_redirect: assert property (@(posedge clk) disable iff (rst)
    stall_o |=> redirect_o);

  // R6
  a_r6_shared_no_stall: assert property (@(posedge clk) disable iff (rst)
    (DEDICATED_ADDER == 0) |-> !stall_o);

  // R5
  a_r5_nottaken_quiet: assert property (@(posedge clk) disable iff (rst)
    (acc && ex_kind_i == 2'b01 && !ex_cond_i && !sec_on) |=> (!redirect_o && !stall_o));

  // R2
  a_r2_shared_secure_redirect: assert property (@(posedge clk) disable iff (rst)
    (acc && ex_kind_i == 2'b01 && sec_on && DEDICATED_ADDER == 0) |=> redirect_o);

  // R9
  a_r9_jump_redirect: assert property (@(posedge clk) disable iff (rst)
    (acc && ex_kind_i == 2'b10) |=>
      (redirect_o && !stall_o && redirect_pc_o == $past(ex_pc_i + ex_imm_i)));
endmodule

bind ct_branch_unit ct_branch_unit_chk #(
  .AW             (AW),
  .SECURE_AVAIL   (SECURE_AVAIL),
  .DEDICATED_ADDER(DEDICATED_ADDER)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .ex_valid_i   (ex_valid_i),
  .ex_kind_i    (ex_kind_i),
  .ex_pc_i      (ex_pc_i),
  .ex_cond_i    (ex_cond_i),
  .ex_imm_i     (ex_imm_i),
  .secure_mode_i(secure_mode_i),
  .redirect_o   (redirect_o),
  .redirect_pc_o(redirect_pc_o),
  .stall_o      (stall_o)
);

// File: tb/ct_branch_unit_bench.sv
`timescale 1ns/1ps
module ct_branch_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid = 1'b0;
  logic [1:0]  kind = 2'b00;
  logic [31:0] pc = '0;
  logic        comp = 1'b0;
  logic        cond = 1'b0;
  logic [31:0] imm = '0;
  logic        sec = 1'b0;

  logic [2:0]  rd;
  logic [2:0]  st;
  logic [31:0] rp [3];

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  // index 0: dedicated adders, 1: shared adder, 2: mode unavailable
  ct_branch_unit #(.AW(32), .SECURE_AVAIL(1), .DEDICATED_ADDER(1)) u_ct_branch_unit (
    .clk(clk), .rst(rst), .ex_valid_i(valid), .ex_kind_i(kind), .ex_pc_i(pc),
    .ex_compressed_i(comp), .ex_cond_i(cond), .ex_imm_i(imm), .secure_mode_i(sec),
    .redirect_o(rd[0]), .redirect_pc_o(rp[0]), .stall_o(st[0]));
  ct_branch_unit #(.AW(32), .SECURE_AVAIL(1), .DEDICATED_ADDER(0)) u_shared (
    .clk(clk), .rst(rst), .ex_valid_i(valid), .ex_kind_i(kind), .ex_pc_i(pc),
    .ex_compressed_i(comp), .ex_cond_i(cond), .ex_imm_i(imm), .secure_mode_i(sec),
    .redirect_o(rd[1]), .redirect_pc_o(rp[1]), .stall_o(st[1]));
  ct_branch_unit #(.AW(32), .SECURE_AVAIL(0), .DEDICATED_ADDER(1)) u_nosec (
    .clk(clk), .rst(rst), .ex_valid_i(valid), .ex_kind_i(kind), .ex_pc_i(pc),
    .ex_compressed_i(comp), .ex_cond_i(cond), .ex_imm_i(imm), .secure_mode_i(sec),
    .redirect_o(rd[2]), .redirect_pc_o(rp[2]), .stall_o(st[2]));

  int          m_lat   [3];
  int          m_cnt   [3];
  int          m_stall [3];
  logic [31:0] m_pc    [3];
  int          s_lat   [3];
  int          s_stall [3];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic sample(input int k);
    for (int d = 0; d < 3; d++) begin
      if (st[d]) m_stall[d]++;
      if (rd[d]) begin
        m_cnt[d]++;
        if (m_lat[d] == 0) begin
          m_lat[d] = k;
          m_pc[d]  = rp[d];
        end
      end
    end
  endtask

  task automatic issue(input logic [1:0] k, input logic [31:0] p, input logic [31:0] im,
                       input bit c, input bit cd, input bit s, input bit flip);
    @(negedge clk);
    valid = 1'b1; kind = k; pc = p; imm = im; comp = c; cond = cd; sec = s;
    @(negedge clk);
    valid = 1'b0; kind = 2'b00;
    if (flip) sec = ~sec;
    for (int d = 0; d < 3; d++) begin
      m_lat[d] = 0; m_cnt[d] = 0; m_stall[d] = 0; m_pc[d] = '0;
    end
    sample(1);
    @(negedge clk); sample(2);
    @(negedge clk); sample(3);
  endtask

  task automatic judge(input logic [1:0] k, input logic [31:0] p, input logic [31:0] im,
                       input bit c, input bit cd, input bit s, input bit flip);
    for (int d = 0; d < 3; d++) begin
      bit avail = (d != 2);
      bit ded   = (d != 1);
      bit act   = s && avail;
      bit is_c  = (k == 2'b01);
      bit is_j  = (k == 2'b10);
      bit take  = is_j || (is_c && cd);
      bit e_red = take || (is_c && act);
      bit two   = ded && is_c && act;
      int e_lat = e_red ? (two ? 2 : 1) : 0;
      int e_st  = two ? 1 : 0;
      logic [31:0] e_pc = take ? (p + im) : (p + (c ? 32'd2 : 32'd4));
      string tag;
      string stag;
      if (!is_c && !is_j)        tag = "R12 idle kind";
      else if (is_j)             tag = "R9 jump";
      else if (flip)             tag = "R10 mode flip";
      else if (s && !avail)      tag = "R1 mode unavailable";
      else if (act)              tag = "R2 secure branch";
      else                       tag = "R5 normal branch";
      stag = two ? "R7 dedicated stall" : ((is_c && act) ? "R6 shared no stall" : tag);
      chk(m_lat[d] == e_lat, {tag, " redirect cycle"}, m_lat[d], e_lat);
      chk(m_cnt[d] == (e_red ? 1 : 0), {tag, " redirect pulses"}, m_cnt[d], e_red ? 1 : 0);
      chk(m_stall[d] == e_st, stag, m_stall[d], e_st);
      if (e_red)
        chk(m_pc[d] == e_pc, take ? "R4 target address" : "R3 sequential address",
            m_pc[d], e_pc);
      if (is_c && s && !flip && d != 2) begin
        if (!cd) begin
          s_lat[d] = m_lat[d]; s_stall[d] = m_stall[d];
        end else begin
          chk(m_lat[d] == s_lat[d], "R8 equal redirect cycle", m_lat[d], s_lat[d]);
          chk(m_stall[d] == s_stall[d], "R8 equal stall count", m_stall[d], s_stall[d]);
        end
      end
    end
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] pcs  [2];
    logic [31:0] imms [2];
    pcs[0] = 32'h0000_1000; imms[0] = 32'h0000_0040;
    pcs[1] = 32'hFFFF_FFFE; imms[1] = 32'hFFFF_FF80;

    repeat (3) @(negedge clk);
    for (int d = 0; d < 3; d++) begin
      chk(rd[d] == 1'b0 && st[d] == 1'b0, "R12 reset outputs", {rd[d], st[d]}, 0);
      chk(rp[d] == 32'h0, "R12 reset address", rp[d], 0);
    end
    rst = 1'b0;
    repeat (2) @(negedge clk);
    for (int d = 0; d < 3; d++)
      chk(rd[d] == 1'b0 && st[d] == 1'b0, "R12 idle after reset", {rd[d], st[d]}, 0);

    for (int pi = 0; pi < 2; pi++)
      for (int k = 0; k < 4; k++)
        for (int c = 0; c < 2; c++)
          for (int s = 0; s < 2; s++)
            for (int f = 0; f < 2; f++)
              for (int cd = 0; cd < 2; cd++) begin
                issue(2'(k), pcs[pi], imms[pi], c[0], cd[0], s[0], f[0]);
                judge(2'(k), pcs[pi], imms[pi], c[0], cd[0], s[0], f[0]);
              end

    // R11: a jump offered during the secure stall must be ignored (dedicated instance).
    @(negedge clk);
    valid = 1'b1; kind = 2'b01; pc = 32'h0000_2000; imm = 32'h0000_0100;
    comp = 1'b0; cond = 1'b0; sec = 1'b1;
    @(negedge clk);
    chk(st[0] == 1'b1, "R11 stall present", st[0], 1);
    kind = 2'b10; imm = 32'h0000_0800;
    @(negedge clk);
    valid = 1'b0; kind = 2'b00;
    chk(rd[0] == 1'b1 && rp[0] == 32'h0000_2004, "R11 branch result kept", rp[0], 32'h0000_2004);
    @(negedge clk);
    chk(rd[0] == 1'b0 && st[0] == 1'b0, "R11 jump during stall ignored", {rd[0], st[0]}, 0);
    repeat (2) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule